// File: doc/BRIEF.md
# Hub Configuration Image Loader

After reset this block pulls a small configuration image out of an external serial memory, one byte at a time, through a byte-fetch stream interface. A separate serial master owns the bus timing. The block issues an address on a valid/ready request channel and takes the returned byte on a valid/ready response channel. Only one fetch is outstanding at a time.

The block reads nine header bytes and then the three string-length bytes. It then checks the header checksum and publishes one complete set of settings. That set is either the values from memory or the built-in defaults. The settings are: vendor and product identifiers, a non-removable port mask, the port count, the maximum bus power, and the three string lengths. A flag shows that the memory image was accepted. A warning flag shows that an accepted image carried a field that had to be corrected. A single `done` pulse tells the rest of the hub that the settings are final.

A separate lock output stays high while the memory is present and is of the serial-peripheral type. The indicator drivers that share pins with that memory use it to stay off.

Top module: `hubcfg_loader`

## Requirements
- R1: With memory present, fetch addresses are issued in the order 0x00..0x08, 0x10, 0x40, 0x70. A new request is raised only after the response to the previous one has been taken.
- R2: Request rule: once `req_valid` is high, `req_addr` holds its value until `req_ready` is seen, or until the request is withdrawn at a timeout. Response rule: `rsp_ready` is high only while a response is awaited, and never together with `req_valid`.
- R3: The image is accepted (`cfg_valid`=1) when byte 4 equals (byte0+byte1+byte2+byte3+1) mod 256. On acceptance, vendor_id={byte1,byte0} and product_id={byte3,byte2}.
- R4: On a checksum mismatch every memory value is ignored. The outputs are then: cfg_valid=0, vendor_id=0x04B4, product_id=0x6572, fixed_mask=0, port_count=NPORTS, max_power=0xFA, all string lengths 0, and range_warn=0.
- R5: On acceptance, fixed_mask[n-1] = bit n of byte 6, for n = 1..NPORTS (1 = non-removable). A 1 in bit 0, or in any bit above NPORTS, is dropped and sets range_warn.
- R6: On acceptance, port_count = byte 7 when it lies in 1..NPORTS. Any other value gives NPORTS and sets range_warn.
- R7: On acceptance, max_power = byte 8 when it is at most 0xFA. A larger value gives 0xFA and sets range_warn.
- R8: On acceptance, the vendor, product and serial string lengths are the bytes read at 0x10, 0x40 and 0x70.
- R9: With eeprom_present low at the first cycle after reset, no request is issued and the defaults of R4 are published.
- R10: If a fetch makes no progress for TMO_CYCLES cycles, fetching stops and the defaults of R4 are published.
- R11: `done` is high for exactly one cycle per reset, in the cycle the settings change to their final values. The settings stay constant afterwards.
- R12: spi_lock equals eeprom_present AND spi_sel as registered one cycle earlier.
- R13: During reset, done=0, req_valid=0, rsp_ready=0, cfg_valid=0, range_warn=0, and the settings outputs hold the R4 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eeprom_present | input | 1 | Configuration memory fitted |
| spi_sel | input | 1 | Fitted memory is of the serial-peripheral type |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Serial master accepts the request |
| req_addr | output | 8 | Byte address of the request |
| rsp_valid | input | 1 | Fetched byte valid |
| rsp_ready | output | 1 | Loader waiting for a byte |
| rsp_data | input | 8 | Fetched byte |
| vendor_id | output | 16 | Published vendor identifier |
| product_id | output | 16 | Published product identifier |
| fixed_mask | output | NPORTS | Non-removable port mask, bit n-1 for port n |
| port_count | output | $clog2(NPORTS+1) | Number of downstream ports |
| max_power | output | 8 | Maximum bus power in 2 mA units |
| vendor_str_len | output | 8 | Vendor string length |
| product_str_len | output | 8 | Product string length |
| serial_str_len | output | 8 | Serial number string length |
| cfg_valid | output | 1 | Memory image accepted |
| range_warn | output | 1 | Accepted image had a field corrected |
| done | output | 1 | One-cycle pulse: settings final |
| spi_lock | output | 1 | Keep shared indicator pins disabled |

## Verification
The hardest state to reach from the ports is a timeout in the middle of the image. By then part of the header has been captured, yet the defaults must still be published. The bench reaches it with its memory model, which answers a set number of fetches and then leaves the next request unacknowledged. It then measures the gap between the last answered fetch and `done`. Back-pressure is also exercised: the model holds `req_ready` low for a varying number of cycles while it watches that the address does not move. Checksum wrap-around and clamping are reached through table vectors with all-ones identifiers and out-of-range count and power bytes.

// File: rtl/hubcfg_pkg.sv
package hubcfg_pkg;

  localparam logic [15:0] DEF_VID   = 16'h04B4;
  localparam logic [15:0] DEF_PID   = 16'h6572;
  localparam logic [7:0]  PWR_LIMIT = 8'hFA;

  // header bytes 0..8, then three string-length bytes
  localparam int unsigned HDR_BYTES = 9;
  localparam int unsigned STEPS     = HDR_BYTES + 3;
  localparam int unsigned IDX_W     = $clog2(STEPS);
  localparam int unsigned KEEP_N    = STEPS - 1;   // last byte is used on the fly

  typedef enum logic [1:0] {
    SQ_BOOT,
    SQ_REQ,
    SQ_RSP,
    SQ_END
  } seq_state_e;

  function automatic logic [7:0] step_addr(input logic [IDX_W-1:0] idx);
    logic [7:0] a;
    if (idx < IDX_W'(HDR_BYTES)) a = 8'(idx);
    else if (idx == IDX_W'(HDR_BYTES)) a = 8'h10;
    else if (idx == IDX_W'(HDR_BYTES + 1)) a = 8'h40;
    else a = 8'h70;
    return a;
  endfunction

endpackage

// File: rtl/hubcfg_fetch_seq.sv
module hubcfg_fetch_seq
  import hubcfg_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             present,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_addr,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  output logic             cap_we,
  output logic [IDX_W-1:0] cap_idx,
  output logic [7:0]       cap_data,
  output logic             fin,
  output logic             fin_ok
);
  localparam int unsigned TW = $clog2(TMO_CYCLES + 1);

  seq_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [TW-1:0]    tmo;
  logic             take, last, progress, expire, waiting;

  always_comb begin
    req_valid = (state == SQ_REQ);
    rsp_ready = (state == SQ_RSP);
    req_addr  = step_addr(idx);
    take      = rsp_valid && rsp_ready;
    last      = (idx == IDX_W'(STEPS - 1));
    waiting   = (state == SQ_REQ) || (state == SQ_RSP);
    progress  = (req_valid && req_ready) || take;
    expire    = waiting && !progress && (tmo == TW'(TMO_CYCLES - 1));
    cap_we    = take;
    cap_idx   = idx;
    cap_data  = rsp_data;
    fin_ok    = take && last;
    fin       = ((state == SQ_BOOT) && !present) || expire || fin_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_BOOT;
      idx   <= '0;
      tmo   <= '0;
    end else begin
      case (state)
        SQ_BOOT: state <= present ? SQ_REQ : SQ_END;
        SQ_REQ: begin
          if (req_ready) begin
            state <= SQ_RSP;
            tmo   <= '0;
          end else if (expire) begin
            state <= SQ_END;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        SQ_RSP: begin
          if (take) begin
            tmo <= '0;
            if (last) state <= SQ_END;
            else begin
              idx   <= idx + 1'b1;
              state <= SQ_REQ;
            end
          end else if (expire) begin
            state <= SQ_END;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        default: state <= SQ_END;
      endcase
    end
  end

  // R2: address held while a request waits (withdrawn only on timeout)
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !fin) |=> (req_valid && $stable(req_addr)));

  // R2: request and response phases never overlap
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R10: the wait window never exceeds the limit
  p_tmo_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo < TW'(TMO_CYCLES));

  // R1: next request follows a taken response
  p_next_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last) |=> (req_valid && req_addr != $past(req_addr)));

endmodule

// File: rtl/hubcfg_image.sv
module hubcfg_image
  import hubcfg_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  localparam int unsigned CW    = $clog2(NPORTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_we,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [7:0]        cap_data,
  input  logic              fin,
  input  logic              fin_ok,
  output logic [15:0]       vendor_id,
  output logic [15:0]       product_id,
  output logic [NPORTS-1:0] fixed_mask,
  output logic [CW-1:0]     port_count,
  output logic [7:0]        max_power,
  output logic [7:0]        vendor_str_len,
  output logic [7:0]        product_str_len,
  output logic [7:0]        serial_str_len,
  output logic              cfg_valid,
  output logic              range_warn,
  output logic              done
);
  localparam logic [7:0] FIELD_BITS = 8'(((1 << NPORTS) - 1) << 1);

  logic [7:0] keep [KEEP_N];

  for (genvar g = 0; g < KEEP_N; g++) begin : g_keep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) keep[g] <= 8'h00;
      else if (cap_we && cap_idx == IDX_W'(g)) keep[g] <= cap_data;
    end
  end

  logic [7:0]    sum;
  logic          accept, rsv_bad, cnt_bad, pwr_bad;
  logic [7:0]    mbyte, cbyte, pbyte;

  always_comb begin
    sum     = keep[0] + keep[1] + keep[2] + keep[3] + 8'd1;
    accept  = fin_ok && (sum == keep[4]);
    mbyte   = keep[6];
    cbyte   = keep[7];
    pbyte   = keep[8];
    rsv_bad = (mbyte & ~FIELD_BITS) != 8'h00;
    cnt_bad = (cbyte == 8'h00) || (cbyte > 8'(NPORTS));
    pwr_bad = pbyte > PWR_LIMIT;
  end

  logic published;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vendor_id       <= DEF_VID;
      product_id      <= DEF_PID;
      fixed_mask      <= '0;
      port_count      <= CW'(NPORTS);
      max_power       <= PWR_LIMIT;
      vendor_str_len  <= 8'h00;
      product_str_len <= 8'h00;
      serial_str_len  <= 8'h00;
      cfg_valid       <= 1'b0;
      range_warn      <= 1'b0;
      done            <= 1'b0;
      published       <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        published <= 1'b1;
        if (accept) begin
          vendor_id       <= {keep[1], keep[0]};
          product_id      <= {keep[3], keep[2]};
          fixed_mask      <= mbyte[NPORTS:1];
          port_count      <= cnt_bad ? CW'(NPORTS) : CW'(cbyte);
          max_power       <= pwr_bad ? PWR_LIMIT : pbyte;
          vendor_str_len  <= keep[HDR_BYTES];
          product_str_len <= keep[HDR_BYTES + 1];
          serial_str_len  <= cap_data;
          cfg_valid       <= 1'b1;
          range_warn      <= rsv_bad || cnt_bad || pwr_bad;
        end else begin
          vendor_id       <= DEF_VID;
          product_id      <= DEF_PID;
          fixed_mask      <= '0;
          port_count      <= CW'(NPORTS);
          max_power       <= PWR_LIMIT;
          vendor_str_len  <= 8'h00;
          product_str_len <= 8'h00;
          serial_str_len  <= 8'h00;
          cfg_valid       <= 1'b0;
          range_warn      <= 1'b0;
        end
      end
    end
  end

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: settings frozen once published
  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    published |=> ($stable(vendor_id) && $stable(product_id) && $stable(cfg_valid)
                   && $stable(port_count) && $stable(max_power)));

  // R4: rejected image carries default identifiers and no warning
  p_default_ids_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (vendor_id == DEF_VID && product_id == DEF_PID && !range_warn));

  // R6: port count always in range
  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_count != '0) && (port_count <= CW'(NPORTS)));

  // R7: power never above the limit
  p_power_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    max_power <= PWR_LIMIT);

endmodule

// File: rtl/hubcfg_loader.sv
module hubcfg_loader
  import hubcfg_pkg::*;
#(
  parameter int unsigned NPORTS     = 4,
  parameter int unsigned TMO_CYCLES = 256,
  localparam int unsigned CW        = $clog2(NPORTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eeprom_present,
  input  logic              spi_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [7:0]        req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  output logic [15:0]       vendor_id,
  output logic [15:0]       product_id,
  output logic [NPORTS-1:0] fixed_mask,
  output logic [CW-1:0]     port_count,
  output logic [7:0]        max_power,
  output logic [7:0]        vendor_str_len,
  output logic [7:0]        product_str_len,
  output logic [7:0]        serial_str_len,
  output logic              cfg_valid,
  output logic              range_warn,
  output logic              done,
  output logic              spi_lock
);
  logic             cap_we, fin, fin_ok;
  logic [IDX_W-1:0] cap_idx;
  logic [7:0]       cap_data;

  hubcfg_fetch_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .present   (eeprom_present),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .cap_we    (cap_we),
    .cap_idx   (cap_idx),
    .cap_data  (cap_data),
    .fin       (fin),
    .fin_ok    (fin_ok)
  );

  hubcfg_image #(.NPORTS(NPORTS)) u_img (
    .clk             (clk),
    .rst_n           (rst_n),
    .cap_we          (cap_we),
    .cap_idx         (cap_idx),
    .cap_data        (cap_data),
    .fin             (fin),
    .fin_ok          (fin_ok),
    .vendor_id       (vendor_id),
    .product_id      (product_id),
    .fixed_mask      (fixed_mask),
    .port_count      (port_count),
    .max_power       (max_power),
    .vendor_str_len  (vendor_str_len),
    .product_str_len (product_str_len),
    .serial_str_len  (serial_str_len),
    .cfg_valid       (cfg_valid),
    .range_warn      (range_warn),
    .done            (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spi_lock <= 1'b0;
    else        spi_lock <= eeprom_present && spi_sel;
  end

  // R12: lock follows the registered memory-type inputs
  p_lock_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (spi_lock == $past(eeprom_present && spi_sel)));

  // R9: no request while memory is absent
  p_absent_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eeprom_present && !req_valid && !rsp_ready && !cfg_valid |=> !cfg_valid);

endmodule

// File: tb/tb_hubcfg_loader.sv
module tb_hubcfg_loader;
  localparam int unsigned NP  = 4;
  localparam int unsigned TMO = 64;

  typedef struct packed {
    logic [15:0] vid;
    logic [15:0] pid;
    logic [7:0]  cdelta;
    logic [7:0]  b6;
    logic [7:0]  b7;
    logic [7:0]  b8;
    logic        ev;
    logic [3:0]  emask;
    logic [2:0]  eports;
    logic [7:0]  epwr;
    logic        ew;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 16'hABCD, 8'h00, 8'h1E, 8'h04, 8'h32, 1'b1, 4'hF, 3'd4, 8'h32, 1'b0},
    '{16'h04B4, 16'h0001, 8'h00, 8'h0A, 8'h02, 8'hFA, 1'b1, 4'h5, 3'd2, 8'hFA, 1'b0},
    '{16'hFFFF, 16'hFFFF, 8'h00, 8'h81, 8'h01, 8'h00, 1'b1, 4'h0, 3'd1, 8'h00, 1'b1},
    '{16'h1111, 16'h2222, 8'h01, 8'h1E, 8'h03, 8'h10, 1'b0, 4'h0, 3'd4, 8'hFA, 1'b0},
    '{16'h5A5A, 16'h0F0F, 8'h00, 8'h02, 8'h00, 8'hFB, 1'b1, 4'h1, 3'd4, 8'hFA, 1'b1},
    '{16'h0000, 16'h0000, 8'h00, 8'h10, 8'h05, 8'h10, 1'b1, 4'h8, 3'd4, 8'h10, 1'b1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, eeprom_present = 1'b0, spi_sel = 1'b0;
  logic        req_ready = 1'b0, rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic        req_valid, rsp_ready, cfg_valid, range_warn, done, spi_lock;
  logic [7:0]  req_addr, max_power, vendor_str_len, product_str_len, serial_str_len;
  logic [15:0] vendor_id, product_id;
  logic [NP-1:0] fixed_mask;
  logic [2:0]  port_count;

  hubcfg_loader #(.NPORTS(NP), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .eeprom_present(eeprom_present), .spi_sel(spi_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .vendor_id(vendor_id), .product_id(product_id), .fixed_mask(fixed_mask),
    .port_count(port_count), .max_power(max_power),
    .vendor_str_len(vendor_str_len), .product_str_len(product_str_len),
    .serial_str_len(serial_str_len), .cfg_valid(cfg_valid),
    .range_warn(range_warn), .done(done), .spi_lock(spi_lock)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_done = 0, done_cyc = 0, n_req_seen = 0, mute_cyc = 0;
  int n_addr = 0;
  logic [7:0] addrs [16];
  logic [7:0] mem [256];
  logic       hold_ok;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input int i);
    if (i < 9) return 8'(i);
    if (i == 9) return 8'h10;
    if (i == 10) return 8'h40;
    return 8'h70;
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (done) begin
      n_done++;
      done_cyc = cyc;
    end
    if (req_valid) n_req_seen++;
  endtask

  task automatic do_reset(input logic pres, input logic sel);
    eeprom_present = pres;
    spi_sel = sel;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(!done && !req_valid && !rsp_ready && !cfg_valid && !range_warn, "R13 flags",
        {done, req_valid, rsp_ready, cfg_valid, range_warn}, 0);
    chk(vendor_id == 16'h04B4 && product_id == 16'h6572 && port_count == 3'd4
        && max_power == 8'hFA && fixed_mask == '0, "R13 settings",
        {vendor_id, product_id}, 32'h04B46572);
    n_done = 0; n_req_seen = 0; n_addr = 0; hold_ok = 1'b1;
    cyc = 0; done_cyc = 0; mute_cyc = 0;
    rst_n = 1'b1;
  endtask

  task automatic serve(input int mute_after, input int delay);
    int guard = 0;
    while (n_done == 0 && guard < 3000) begin
      tick();
      guard++;
      if (req_valid && n_addr < mute_after) begin
        logic [7:0] a = req_addr;
        for (int k = 0; k < delay; k++) begin
          tick();
          if (!req_valid || req_addr != a) hold_ok = 1'b0;
        end
        req_ready = 1'b1;
        tick();
        req_ready = 1'b0;
        addrs[n_addr] = a;
        n_addr++;
        for (int k = 0; k < delay; k++) tick();
        rsp_valid = 1'b1;
        rsp_data = mem[a];
        tick();
        rsp_valid = 1'b0;
        if (n_addr == mute_after) mute_cyc = cyc;
      end
    end
    repeat (5) tick();
  endtask

  task automatic fill(input vec_t v, input int seed);
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    mem[0] = v.vid[7:0];  mem[1] = v.vid[15:8];
    mem[2] = v.pid[7:0];  mem[3] = v.pid[15:8];
    mem[4] = v.vid[7:0] + v.vid[15:8] + v.pid[7:0] + v.pid[15:8] + 8'd1 + v.cdelta;
    mem[6] = v.b6; mem[7] = v.b7; mem[8] = v.b8;
    mem[8'h10] = 8'h0A + 8'(seed); mem[8'h11] = 8'h03;
    mem[8'h40] = 8'h14 + 8'(seed); mem[8'h41] = 8'h03;
    mem[8'h70] = 8'h1E + 8'(seed); mem[8'h71] = 8'h03;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic order_ok;
    // table of vectors
    for (int v = 0; v < NV; v++) begin
      fill(VECS[v], v);
      do_reset(1'b1, 1'b0);
      serve(99, v % 3);
      order_ok = (n_addr == 12);
      for (int i = 0; i < 12 && i < n_addr; i++)
        if (addrs[i] != exp_addr(i)) order_ok = 1'b0;
      chk(order_ok, "R1 fetch order", n_addr, 12);
      chk(hold_ok, "R2 address hold under back-pressure", hold_ok, 1);
      chk(cfg_valid == VECS[v].ev, "R3/R4 cfg_valid", cfg_valid, VECS[v].ev);
      chk(vendor_id == (VECS[v].ev ? VECS[v].vid : 16'h04B4), "R3/R4 vendor_id",
          vendor_id, VECS[v].ev ? VECS[v].vid : 16'h04B4);
      chk(product_id == (VECS[v].ev ? VECS[v].pid : 16'h6572), "R3/R4 product_id",
          product_id, VECS[v].ev ? VECS[v].pid : 16'h6572);
      chk(fixed_mask == VECS[v].emask, "R5 fixed_mask", fixed_mask, VECS[v].emask);
      chk(port_count == VECS[v].eports, "R6 port_count", port_count, VECS[v].eports);
      chk(max_power == VECS[v].epwr, "R7 max_power", max_power, VECS[v].epwr);
      chk(range_warn == VECS[v].ew, "R5/R6/R7 range_warn", range_warn, VECS[v].ew);
      chk(serial_str_len == (VECS[v].ev ? 8'h1E + 8'(v) : 8'h00)
          && vendor_str_len == (VECS[v].ev ? 8'h0A + 8'(v) : 8'h00)
          && product_str_len == (VECS[v].ev ? 8'h14 + 8'(v) : 8'h00),
          "R8 string lengths", {vendor_str_len, product_str_len, serial_str_len},
          VECS[v].ev ? {8'h0A + 8'(v), 8'h14 + 8'(v), 8'h1E + 8'(v)} : 24'h0);
      chk(n_done == 1, "R11 single done pulse", n_done, 1);
    end

    // R9: memory absent
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) tick();
    chk(n_req_seen == 0, "R9 no request when absent", n_req_seen, 0);
    chk(n_done == 1, "R9 done when absent", n_done, 1);
    chk(!cfg_valid && vendor_id == 16'h04B4 && product_id == 16'h6572,
        "R9 defaults when absent", {cfg_valid, vendor_id}, 32'h04B4);

    // R10: master stops answering after five fetches
    fill(VECS[0], 0);
    do_reset(1'b1, 1'b0);
    serve(5, 1);
    chk(n_addr == 5, "R10 fetches before stall", n_addr, 5);
    chk(n_done == 1, "R10 done after timeout", n_done, 1);
    chk(done_cyc - mute_cyc >= TMO, "R10 timeout not early", done_cyc - mute_cyc, TMO);
    chk(!cfg_valid && vendor_id == 16'h04B4 && port_count == 3'd4 && max_power == 8'hFA
        && serial_str_len == 8'h00, "R10 defaults after timeout",
        {cfg_valid, vendor_id}, 32'h04B4);

    // R11: no second pulse long after completion
    for (int i = 0; i < 100; i++) tick();
    chk(n_done == 1, "R11 no later pulse", n_done, 1);

    // R12: lock output
    do_reset(1'b1, 1'b1);
    tick(); tick();
    chk(spi_lock == 1'b1, "R12 lock high", spi_lock, 1);
    spi_sel = 1'b0;
    tick(); tick();
    chk(spi_lock == 1'b0, "R12 lock low for other type", spi_lock, 0);
    eeprom_present = 1'b0;
    spi_sel = 1'b1;
    tick(); tick();
    chk(spi_lock == 1'b0, "R12 lock low when absent", spi_lock, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule